// File: doc/BRIEF.md
# Shared-Memory Channel Access Sequencer

This block lets a hardware coprocessor act as a producer or consumer on a multi-writer, multi-reader FIFO channel that lives in shared memory as a software-managed ring buffer. Several agents may use one channel, so each access runs as a locked transaction. The block claims the channel lock with a load-linked / store-conditional pair. It reads the three-word channel state, then checks whether the channel holds enough items (for a read) or enough free room (for a write). It copies the items word by word between the coprocessor's local buffer and the ring buffer. Last, it writes the state back, and the final word of that write clears the lock.

The task side makes a request with a direction, an item count and a try flag. The block answers with a one-cycle completion pulse and an ok flag. Items are whole 32-bit words: the item width is given in words and the ring depth in items. The lock, state and ring base addresses are static configuration inputs. In try mode a shortfall ends the request with ok low. In blocking mode the block releases the lock and starts the whole transaction again until the transfer fits.

Top module: `mwmr_chan_ctrl`

## Requirements
- R1: Every transaction issues its memory operations in this order: LL on the lock address, SC on the lock address, reads of the state words at state base +0 (item count), +4 (read index), +8 (write index), the data beats, writes of count, read index and write index to the same three addresses, and finally a write of 0 to the lock address.
- R2: An LL that returns a nonzero lock word is followed by another LL, and no SC is issued until an LL returns zero.
- R3: An SC whose returned bit 0 is 0 has failed, and the transaction restarts at the LL. An SC writes the value 1.
- R4: A read request (reqWrite=0) succeeds when the stored count is at least reqItems. Ring words are copied in order into local buffer addresses 0, 1, 2, and so on. The count drops by reqItems and the read index advances by reqItems modulo depth.
- R5: A write request (reqWrite=1) succeeds when depth minus count is at least reqItems. Local buffer words 0, 1, 2, and so on are written in order into the ring. The count rises by reqItems and the write index advances by reqItems modulo depth.
- R6: Word w of ring item i sits at byte address ringBase + (i*widthWords + w)*4. Item indices wrap from depth-1 to 0 inside one burst.
- R7: In try mode, a shortfall produces no data beats and no local buffer writes. The unchanged state is written back, the lock is released, and the request ends with doneOk=0.
- R8: In blocking mode, a shortfall writes back the unchanged state, releases the lock and restarts at the LL. The request ends only when the transfer succeeds, with doneOk=1.
- R9: reqReady is high only when the block is idle, and a reqValid seen while busy is ignored. Each request ends with donePulse high for exactly one cycle, together with doneOk. After reset, reqReady=1 and memReq=0.
- R10: memOp encodes 0=read, 1=write, 2=LL, 3=SC. Once memReq is raised, memOp, memAddr and memWdata stay constant until the cycle in which memAck is high.
- R11: A request for zero items performs the lock, state read and state write-back with no data beats. It leaves the state unchanged and ends with doneOk=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLockAddr | input | AW | Byte address of the channel lock word |
| cfgStatusAddr | input | AW | Byte address of the three-word channel state |
| cfgBufAddr | input | AW | Byte address of ring item 0 |
| cfgWidthWords | input | WW | Item width in 32-bit words (at least 1) |
| cfgDepth | input | CW | Ring capacity in items (at least 1) |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = coprocessor writes into the channel, 0 = reads from it |
| reqTry | input | 1 | 1 = fail instead of retrying on a shortfall |
| reqItems | input | CW | Number of items to move |
| reqReady | output | 1 | Idle, a request can be taken |
| donePulse | output | 1 | One-cycle end-of-request pulse |
| doneOk | output | 1 | Outcome, valid with donePulse |
| memReq | output | 1 | Memory operation request |
| memOp | output | 2 | Operation code (see R10) |
| memAddr | output | AW | Byte address |
| memWdata | output | DW | Write data (write and SC) |
| memAck | input | 1 | Operation complete, read data valid |
| memRdata | input | DW | Read, LL or SC result |
| locAddr | output | LW | Local buffer word address |
| locWe | output | 1 | Local buffer write enable |
| locWdata | output | DW | Local buffer write data |
| locRdata | input | DW | Local buffer read data, combinational in locAddr |

## Verification
Embedded properties watch the invariants that hold on every cycle. These are: the memory request stays stable until its acknowledge, an SC is always preceded by an acknowledged LL, reqReady is low while the memory port is busy, the completion pulse lasts one cycle, the ring index stays below the depth during data beats, and the committed count stays within capacity. The ordering and content of a whole transaction can only be shown by the bench scenarios. These cover the exact address and data trace, index wrap across the ring end, the try-mode and blocking-mode shortfall paths, lock spinning, SC failure, zero-item requests and a request ignored while busy.

// File: rtl/mwmr_pkg.sv
package mwmr_pkg;

  typedef enum logic [1:0] {
    OP_RD = 2'd0,
    OP_WR = 2'd1,
    OP_LL = 2'd2,
    OP_SC = 2'd3
  } memOp_e;

  typedef enum logic [1:0] {
    SEL_LOCK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BUF  = 2'd2
  } addrSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     ldReq;
    logic     ldStat;
    logic     initBurst;
    logic     stepBurst;
    logic     commit;
    logic     relLock;
    logic [1:0] beat;
    addrSel_e addrSel;
  } dpStrobe_t;

endpackage

// File: rtl/mwmr_dp.sv
module mwmr_dp
  import mwmr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int WW = 8,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     st,
  input  logic          reqWrite,
  input  logic          reqTry,
  input  logic [CW-1:0] reqItems,
  input  logic [AW-1:0] cfgLockAddr,
  input  logic [AW-1:0] cfgStatusAddr,
  input  logic [AW-1:0] cfgBufAddr,
  input  logic [WW-1:0] cfgWidthWords,
  input  logic [CW-1:0] cfgDepth,
  input  logic [DW-1:0] memRdata,
  input  logic [DW-1:0] locRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [LW-1:0] locAddr,
  output logic          isWrite,
  output logic          isTry,
  output logic          enough,
  output logic          noItems,
  output logic          lastWord,
  output logic          lockFree,
  output logic          scOk
);

  logic          rWrite, rTry;
  logic [CW-1:0] rItems;
  logic [CW-1:0] stCount, stRd, stWr;
  logic [CW-1:0] curItem, itemsLeft, nextCur, wrapCur;
  logic [WW-1:0] wordIdx;
  logic [LW-1:0] locIdx;
  logic          wordLast;
  logic [AW-1:0] wordOff;

  assign isWrite  = rWrite;
  assign isTry    = rTry;
  assign noItems  = (rItems == '0);
  assign enough   = rWrite ? ((cfgDepth - stCount) >= rItems) : (stCount >= rItems);
  assign wordLast = (wordIdx == cfgWidthWords - WW'(1));
  assign lastWord = wordLast && (itemsLeft == CW'(1));
  assign wrapCur  = (curItem == cfgDepth - CW'(1)) ? '0 : curItem + CW'(1);
  assign nextCur  = (st.stepBurst && wordLast) ? wrapCur : curItem;
  assign lockFree = (memRdata == '0);
  assign scOk     = memRdata[0];
  assign locAddr  = locIdx;

  assign wordOff = AW'(curItem) * AW'(cfgWidthWords) + AW'(wordIdx);

  always_comb begin
    unique case (st.addrSel)
      SEL_LOCK: memAddr = cfgLockAddr;
      SEL_STAT: memAddr = cfgStatusAddr + (AW'(st.beat) << 2);
      SEL_BUF:  memAddr = cfgBufAddr + (wordOff << 2);
      default:  memAddr = cfgLockAddr;
    endcase
  end

  always_comb begin
    memWdata = '0;
    unique case (st.addrSel)
      SEL_LOCK: memWdata = st.relLock ? '0 : DW'(1);
      SEL_STAT: begin
        unique case (st.beat)
          2'd0:    memWdata = DW'(stCount);
          2'd1:    memWdata = DW'(stRd);
          2'd2:    memWdata = DW'(stWr);
          default: memWdata = '0;
        endcase
      end
      SEL_BUF:  memWdata = locRdata;
      default:  memWdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rWrite    <= 1'b0;
      rTry      <= 1'b0;
      rItems    <= '0;
      stCount   <= '0;
      stRd      <= '0;
      stWr      <= '0;
      curItem   <= '0;
      itemsLeft <= '0;
      wordIdx   <= '0;
      locIdx    <= '0;
    end else begin
      if (st.ldReq) begin
        rWrite <= reqWrite;
        rTry   <= reqTry;
        rItems <= reqItems;
      end
      if (st.ldStat) begin
        unique case (st.beat)
          2'd0:    stCount <= memRdata[CW-1:0];
          2'd1:    stRd    <= memRdata[CW-1:0];
          2'd2:    stWr    <= memRdata[CW-1:0];
          default: ;
        endcase
      end
      if (st.initBurst) begin
        curItem   <= rWrite ? stWr : stRd;
        itemsLeft <= rItems;
        wordIdx   <= '0;
        locIdx    <= '0;
      end else if (st.stepBurst) begin
        locIdx <= locIdx + LW'(1);
        if (wordLast) begin
          wordIdx   <= '0;
          itemsLeft <= itemsLeft - CW'(1);
          curItem   <= wrapCur;
        end else begin
          wordIdx <= wordIdx + WW'(1);
        end
      end
      if (st.commit) begin
        if (rWrite) begin
          stCount <= stCount + rItems;
          stWr    <= nextCur;
        end else begin
          stCount <= stCount - rItems;
          stRd    <= nextCur;
        end
      end
    end
  end

  // R6
  buf_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.addrSel == SEL_BUF) |-> (curItem < cfgDepth && wordIdx < cfgWidthWords));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> (stCount <= cfgDepth));

endmodule

// File: rtl/mwmr_ctl.sv
module mwmr_ctl
  import mwmr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memAck,
  input  logic      isWrite,
  input  logic      isTry,
  input  logic      enough,
  input  logic      noItems,
  input  logic      lastWord,
  input  logic      lockFree,
  input  logic      scOk,
  output dpStrobe_t st,
  output logic      memReq,
  output memOp_e    memOp,
  output logic      reqReady,
  output logic      locWe,
  output logic      donePulse,
  output logic      doneOk
);

  typedef enum logic [2:0] {
    S_IDLE, S_LL, S_SC, S_SRD, S_CHK, S_BST, S_SWR
  } state_e;

  state_e     state;
  logic [1:0] beat;
  logic       okFlag;
  logic       doneP, doneOkR;
  memOp_e     lastAckOp;

  assign reqReady  = (state == S_IDLE);
  assign locWe     = (state == S_BST) && !isWrite && memAck;
  assign donePulse = doneP;
  assign doneOk    = doneOkR;

  always_comb begin
    st         = '0;
    st.beat    = beat;
    st.addrSel = SEL_LOCK;
    memReq     = 1'b0;
    memOp      = OP_RD;
    unique case (state)
      S_IDLE: st.ldReq = reqValid;
      S_LL: begin
        memReq = 1'b1;
        memOp  = OP_LL;
      end
      S_SC: begin
        memReq = 1'b1;
        memOp  = OP_SC;
      end
      S_SRD: begin
        memReq     = 1'b1;
        st.addrSel = SEL_STAT;
        st.ldStat  = memAck;
      end
      S_CHK: st.initBurst = enough && !noItems;
      S_BST: begin
        memReq       = 1'b1;
        memOp        = isWrite ? OP_WR : OP_RD;
        st.addrSel   = SEL_BUF;
        st.stepBurst = memAck;
        st.commit    = memAck && lastWord;
      end
      S_SWR: begin
        memReq     = 1'b1;
        memOp      = OP_WR;
        st.relLock = 1'b1;
        st.addrSel = (beat == 2'd3) ? SEL_LOCK : SEL_STAT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      beat      <= '0;
      okFlag    <= 1'b0;
      doneP     <= 1'b0;
      doneOkR   <= 1'b0;
      lastAckOp <= OP_RD;
    end else begin
      doneP <= 1'b0;
      if (memReq && memAck) lastAckOp <= memOp;
      unique case (state)
        S_IDLE: if (reqValid) state <= S_LL;
        S_LL:   if (memAck && lockFree) state <= S_SC;
        S_SC: if (memAck) begin
          beat  <= '0;
          state <= scOk ? S_SRD : S_LL;
        end
        S_SRD: if (memAck) begin
          if (beat == 2'd2) begin
            beat  <= '0;
            state <= S_CHK;
          end else begin
            beat <= beat + 2'd1;
          end
        end
        S_CHK: begin
          okFlag <= enough;
          beat   <= '0;
          state  <= (enough && !noItems) ? S_BST : S_SWR;
        end
        S_BST: if (memAck && lastWord) begin
          beat  <= '0;
          state <= S_SWR;
        end
        S_SWR: if (memAck) begin
          if (beat == 2'd3) begin
            beat <= '0;
            if (okFlag || isTry) begin
              state   <= S_IDLE;
              doneP   <= 1'b1;
              doneOkR <= okFlag;
            end else begin
              state <= S_LL;
            end
          end else begin
            beat <= beat + 2'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

  // R1
  sc_after_ll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp == OP_SC) |-> (lastAckOp == OP_LL));

endmodule

// File: rtl/mwmr_chan_ctrl.sv
module mwmr_chan_ctrl
  import mwmr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int WW = 8,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] cfgLockAddr,
  input  logic [AW-1:0] cfgStatusAddr,
  input  logic [AW-1:0] cfgBufAddr,
  input  logic [WW-1:0] cfgWidthWords,
  input  logic [CW-1:0] cfgDepth,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic          reqTry,
  input  logic [CW-1:0] reqItems,
  output logic          reqReady,
  output logic          donePulse,
  output logic          doneOk,
  output logic          memReq,
  output logic [1:0]    memOp,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata,
  output logic [LW-1:0] locAddr,
  output logic          locWe,
  output logic [DW-1:0] locWdata,
  input  logic [DW-1:0] locRdata
);

  dpStrobe_t st;
  memOp_e    opInt;
  logic      isWrite, isTry, enough, noItems, lastWord, lockFree, scOk;

  assign memOp    = opInt;
  assign locWdata = memRdata;

  mwmr_ctl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .isWrite(isWrite), .isTry(isTry), .enough(enough), .noItems(noItems),
    .lastWord(lastWord), .lockFree(lockFree), .scOk(scOk),
    .st(st), .memReq(memReq), .memOp(opInt), .reqReady(reqReady),
    .locWe(locWe), .donePulse(donePulse), .doneOk(doneOk)
  );

  mwmr_dp #(.AW(AW), .DW(DW), .CW(CW), .WW(WW), .LW(LW)) uDp (
    .clk(clk), .rstN(rstN), .st(st),
    .reqWrite(reqWrite), .reqTry(reqTry), .reqItems(reqItems),
    .cfgLockAddr(cfgLockAddr), .cfgStatusAddr(cfgStatusAddr),
    .cfgBufAddr(cfgBufAddr), .cfgWidthWords(cfgWidthWords), .cfgDepth(cfgDepth),
    .memRdata(memRdata), .locRdata(locRdata),
    .memAddr(memAddr), .memWdata(memWdata), .locAddr(locAddr),
    .isWrite(isWrite), .isTry(isTry), .enough(enough), .noItems(noItems),
    .lastWord(lastWord), .lockFree(lockFree), .scOk(scOk)
  );

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memOp) && $stable(memAddr) && $stable(memWdata)));

endmodule

// File: tb/sim_mwmr_chan_ctrl.sv
module sim_mwmr_chan_ctrl;

  localparam logic [31:0] LOCKA = 32'h0;
  localparam logic [31:0] STATA = 32'h10;
  localparam logic [31:0] BUFA  = 32'h40;
  localparam int BUFW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgLockAddr = LOCKA, cfgStatusAddr = STATA, cfgBufAddr = BUFA;
  logic [7:0]  cfgWidthWords = 8'd1;
  logic [15:0] cfgDepth = 16'd4;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqTry = 1'b0;
  logic [15:0] reqItems = '0;
  logic        reqReady, donePulse, doneOk, memReq, locWe;
  logic [1:0]  memOp;
  logic [31:0] memAddr, memWdata, locWdata, locRdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic [9:0]  locAddr;

  always #4 clk = ~clk;

  mwmr_chan_ctrl u0 (.*);

  // memory and local buffer models
  logic [31:0] mem [128];
  logic [31:0] loc [64];
  logic [1:0]  logOp [512];
  logic [31:0] logAddr [512];
  logic [31:0] logData [512];
  int          logN = 0, scCnt = 0, relCnt = 0, gapN = 0;
  logic        pokeEn = 0, locPokeEn = 0, clrLog = 0;
  logic [6:0]  pokeIdx = '0;
  logic [5:0]  locPokeIdx = '0;
  logic [31:0] pokeVal = '0, locPokeVal = '0;
  int          scFailN = 0, injAt = 0;
  logic [31:0] injCnt = '0, injWr = '0;

  int nChk = 0, nBad = 0;
  logic [31:0] bufSave [32];
  logic [31:0] locSave [32];

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (pokeEn) mem[pokeIdx] <= pokeVal;
    if (clrLog) begin
      logN <= 0; scCnt <= 0; relCnt <= 0;
    end else if (memReq && !memAck) begin
      if (gapN != 0) gapN <= gapN - 1;
      else begin
        gapN <= $urandom_range(0, 2);
        memAck <= 1'b1;
        logOp[logN[8:0]] <= memOp;
        logAddr[logN[8:0]] <= memAddr;
        logData[logN[8:0]] <= memWdata;
        logN <= logN + 1;
        case (memOp)
          2'd0, 2'd2: memRdata <= mem[memAddr[8:2]];
          2'd1: begin
            mem[memAddr[8:2]] <= memWdata;
            if (memAddr == LOCKA) begin
              relCnt <= relCnt + 1;
              if (relCnt + 1 == injAt) begin
                mem[4] <= injCnt;
                mem[6] <= injWr;
              end
            end
          end
          default: begin
            scCnt <= scCnt + 1;
            if (scCnt < scFailN) memRdata <= 32'h0;
            else begin
              mem[memAddr[8:2]] <= memWdata;
              memRdata <= 32'h1;
            end
          end
        endcase
      end
    end
  end

  always @(posedge clk) begin
    if (locPokeEn) loc[locPokeIdx] <= locPokeVal;
    if (locWe) loc[locAddr[5:0]] <= locWdata;
  end
  assign locRdata = loc[locAddr[5:0]];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pokeMem(input int idx, input logic [31:0] v);
    @(negedge clk); pokeEn = 1; pokeIdx = idx[6:0]; pokeVal = v;
    @(negedge clk); pokeEn = 0;
  endtask

  task automatic pokeLoc(input int idx, input logic [31:0] v);
    @(negedge clk); locPokeEn = 1; locPokeIdx = idx[5:0]; locPokeVal = v;
    @(negedge clk); locPokeEn = 0;
  endtask

  task automatic clearLog();
    @(negedge clk); clrLog = 1;
    @(negedge clk); clrLog = 0;
  endtask

  task automatic prep(input int w, input int d, input int cnt, input int rd, input int n);
    @(negedge clk);
    cfgWidthWords = 8'(w);
    cfgDepth = 16'(d);
    pokeMem(0, 32'h0);
    pokeMem(4, 32'(cnt));
    pokeMem(5, 32'(rd));
    pokeMem(6, 32'((rd + cnt) % d));
    for (int i = 0; i < w * d; i++) begin
      bufSave[i] = $urandom;
      pokeMem(BUFW + i, bufSave[i]);
    end
    for (int i = 0; i < n * w; i++) begin
      locSave[i] = $urandom;
      pokeLoc(i, locSave[i]);
    end
    clearLog();
  endtask

  task automatic issue(input bit dir, input bit tryMode, input int n);
    @(negedge clk);
    reqValid = 1; reqWrite = dir; reqTry = tryMode; reqItems = 16'(n);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone(input string req, output bit ok);
    bit got = 0;
    ok = 0;
    for (int c = 0; c < 20000 && !got; c++) begin
      @(negedge clk);
      if (donePulse) begin got = 1; ok = doneOk; end
    end
    chk(req, "done seen", got, 1);
    @(negedge clk);
    chk(req, "done width", donePulse, 0);
  endtask

  function automatic int countOp(input int op, input logic [31:0] a);
    int k = 0;
    for (int i = 0; i < logN; i++) if (logOp[i] == op[1:0] && logAddr[i] == a) k++;
    return k;
  endfunction

  // checks outcome, final state, data and (optionally) the exact trace
  task automatic verify(input string req, input bit dir, input int n, input int cnt,
                        input int rd, input int w, input int d, input bit ok, input bit exact);
    int wr = (rd + cnt) % d;
    bit expOk = dir ? (d - cnt >= n) : (cnt >= n);
    int nc = cnt, nr = rd, nw = wr, e = 0;
    int eOp [128];
    logic [31:0] eAddr [128];
    logic [31:0] eData [128];
    bit eDc [128];
    chk(req, "doneOk", ok, expOk);
    if (expOk && n > 0) begin
      if (dir) begin nc = cnt + n; nw = (wr + n) % d; end
      else begin nc = cnt - n; nr = (rd + n) % d; end
    end
    chk(req, "count", mem[4], nc);
    chk(req, "read idx", mem[5], nr);
    chk(req, "write idx", mem[6], nw);
    chk(req, "lock released", mem[0], 0);
    for (int k = 0; k < n * w; k++) begin
      int p = ((dir ? wr : rd) + k / w) % d;
      int wi = p * w + k % w;
      if (dir) chk(req, "ring word", mem[BUFW + wi], (expOk ? locSave[k] : bufSave[wi]));
      else     chk(req, "local word", loc[k], (expOk ? bufSave[wi] : locSave[k]));
    end
    if (exact) begin
      eOp[0] = 2; eAddr[0] = LOCKA; eDc[0] = 1; eData[0] = 0;
      eOp[1] = 3; eAddr[1] = LOCKA; eDc[1] = 0; eData[1] = 1;
      for (int b = 0; b < 3; b++) begin
        eOp[2+b] = 0; eAddr[2+b] = STATA + 32'(4*b); eDc[2+b] = 1; eData[2+b] = 0;
      end
      e = 5;
      if (expOk) for (int k = 0; k < n * w; k++) begin
        int p = ((dir ? wr : rd) + k / w) % d;
        eOp[e] = dir ? 1 : 0;
        eAddr[e] = BUFA + 32'((p * w + k % w) * 4);
        eDc[e] = !dir; eData[e] = dir ? locSave[k] : 0;
        e++;
      end
      eOp[e] = 1; eAddr[e] = STATA;     eDc[e] = 0; eData[e] = 32'(nc); e++;
      eOp[e] = 1; eAddr[e] = STATA + 4; eDc[e] = 0; eData[e] = 32'(nr); e++;
      eOp[e] = 1; eAddr[e] = STATA + 8; eDc[e] = 0; eData[e] = 32'(nw); e++;
      eOp[e] = 1; eAddr[e] = LOCKA;     eDc[e] = 0; eData[e] = 0;       e++;
      chk(req, "trace length", logN, e);
      for (int i = 0; i < e && i < logN; i++) begin
        chk(req, "trace op", logOp[i], eOp[i]);
        chk(req, "trace addr", logAddr[i], eAddr[i]);
        if (!eDc[i]) chk(req, "trace data", logData[i], eData[i]);
      end
    end
  endtask

  task automatic runOne(input string req, input bit dir, input bit tryMode, input int n,
                        input int cnt, input int rd, input int w, input int d);
    bit ok;
    prep(w, d, cnt, rd, n);
    issue(dir, tryMode, n);
    waitDone(req, ok);
    verify(req, dir, n, cnt, rd, w, d, ok, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int seedInit;
    bit ok;
    seedInit = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9 reset", "reqReady", reqReady, 1);
    chk("R9 reset", "memReq", memReq, 0);
    chk("R9 reset", "donePulse", donePulse, 0);
    rstN = 1;

    runOne("R4 R6 read wrap", 0, 1, 3, 4, 3, 2, 5);
    runOne("R5 R6 write wrap", 1, 1, 3, 1, 2, 3, 4);
    runOne("R5 fill to capacity", 1, 1, 4, 0, 1, 1, 4);
    runOne("R4 drain all", 0, 1, 4, 4, 2, 2, 4);
    runOne("R7 try read short", 0, 1, 2, 1, 0, 2, 4);
    runOne("R7 try write short", 1, 1, 2, 3, 1, 1, 4);
    runOne("R11 zero items", 0, 1, 0, 2, 1, 2, 4);

    // R2 lock held by another agent
    prep(1, 4, 2, 0, 1);
    pokeMem(0, 32'h1);
    issue(0, 1, 1);
    repeat (30) @(negedge clk);
    chk("R2 spin", "SC before free", countOp(3, LOCKA), 0);
    chk("R2 spin", "LL repeated", (countOp(2, LOCKA) >= 2), 1);
    pokeMem(0, 32'h0);
    waitDone("R2 spin", ok);
    verify("R2 spin", 0, 1, 2, 0, 1, 4, ok, 0);

    // R3 store-conditional failures
    scFailN = 2;
    prep(2, 4, 0, 1, 2);
    issue(1, 1, 2);
    waitDone("R3 sc fail", ok);
    chk("R3 sc fail", "LL count", countOp(2, LOCKA), 3);
    chk("R3 sc fail", "SC count", countOp(3, LOCKA), 3);
    verify("R3 sc fail", 1, 2, 0, 1, 2, 4, ok, 0);
    scFailN = 0;

    // R8 blocking read waits for a producer
    injAt = 2; injCnt = 32'd4; injWr = 32'd0;
    prep(1, 6, 1, 2, 3);
    issue(0, 0, 3);
    waitDone("R8 blocking", ok);
    chk("R8 blocking", "LL count", countOp(2, LOCKA), 3);
    chk("R8 blocking", "releases", countOp(1, LOCKA), 3);
    verify("R8 blocking", 0, 3, 4, 2, 1, 6, ok, 0);
    injAt = 0;

    // R9 request while busy is ignored
    prep(1, 4, 3, 1, 2);
    issue(0, 1, 2);
    repeat (3) @(negedge clk);
    chk("R9 busy", "reqReady", reqReady, 0);
    reqValid = 1; reqWrite = 1; reqItems = 16'd1;
    @(negedge clk);
    reqValid = 0;
    waitDone("R9 busy", ok);
    verify("R9 busy", 0, 2, 3, 1, 1, 4, ok, 1);
    begin
      int busy = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (memReq || donePulse) busy++;
      end
      chk("R9 busy", "idle after done", busy, 0);
    end

    // R1 R4 R5 R10 random try-mode traffic
    for (int t = 0; t < 24; t++) begin
      int w = $urandom_range(1, 3);
      int d = $urandom_range(2, 8);
      int cnt = $urandom_range(0, d);
      int rd = $urandom_range(0, d - 1);
      int n = $urandom_range(0, d);
      bit dir = 1'($urandom_range(0, 1));
      runOne("R1 R4 R5 R10 random", dir, 1, n, cnt, rd, w, d);
    end

    summary();
    $finish;
  end

endmodule